// File: doc/BRIEF.md
# Staircase Level Selector with Adjustable Step Point

This block turns a signed reference sample into the output level of a cascaded full-bridge inverter built from `NCELL` equal DC cells. It returns a signed level index between -NCELL and +NCELL (2·NCELL+1 levels) and the four switch drives of every cell. One level height is fixed at 2^FRAC_W counts of the reference. The magnitude of the reference therefore splits into an integer level and a fraction by a plain bit split, and the sign is put back on the index afterwards.

The point inside each level where the output steps up is a threshold held in a small register, in tenths of a level. A threshold of 5 gives ordinary round-half-up behaviour. Lower settings, such as the favoured 4, step up earlier and raise the fundamental. The threshold may only be written while no sample is being taken, so a sample never sees a value that is changing. A sample is taken on each clock edge where the sample enable is high. Outputs are registered and hold between samples.

Top module: `stair_nlm`

## Requirements
- R1: With reference r, magnitude m = |r|, integer part q = floor(m / 2^FRAC_W) and fraction f = m - q·2^FRAC_W, the level index is sign(r)·min(NCELL, q + u). Here u = 1 when f > 0 and 10·f >= t·2^FRAC_W for threshold t (in tenths), and u = 0 otherwise. With the defaults, FRAC_W = 10 and NCELL = 5.
- R2: After reset the threshold is 5, so a fraction of exactly half a level steps up and one count less does not.
- R3: Negative references follow the same rule on their magnitude, so the index of -r is the negation of the index of r.
- R4: The threshold spans 0 to 10. A write of a value above 10 stores 10, which gives pure truncation; 0 gives rounding up of any nonzero fraction; 4 steps up at four tenths.
- R5: A reference beyond full scale, including -2^(REF_W-1), yields exactly +NCELL or -NCELL.
- R6: A threshold write takes effect at a clock edge only when smp_en is low at that edge. A write made while smp_en is high is dropped and the sample in that cycle uses the old value.
- R7: lvl_idx and gate change only at an edge where smp_en is high, one clock after the sample is presented, and otherwise hold.
- R8: Cell k drives bits [4k+3:4k] of gate: bit0 left high-side, bit1 left low-side, bit2 right high-side, bit3 right low-side. The cell outputs +1 (4'b1001) when k < lvl_idx, outputs -1 (4'b0110) when k < -lvl_idx, and otherwise bypasses (4'b0101), so cell 0 is engaged first.
- R9: While rst_n is low, lvl_idx is 0 and every gate bit is 0 (all switches off).
- R10: No cell ever turns on both switches of one leg.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_en | input | 1 | Take a sample of ref_in at this edge |
| ref_in | input | REF_W | Signed reference, 2^FRAC_W counts per level |
| thr_wr | input | 1 | Threshold write strobe |
| thr_val | input | 4 | Threshold in tenths of a level |
| lvl_idx | output | $clog2(NCELL+1)+1 | Signed selected level index |
| gate | output | 4*NCELL | Switch drives, four per cell |

## Verification
A threshold write and a sample can fall in the same cycle. The bench provokes this by raising thr_wr and smp_en on the same edge, with a reference whose fraction makes the old and new thresholds give different levels. It then takes a second sample of the same reference with no write. Both results must match the index for the old threshold, which shows that the sample used the old value and that the write was dropped rather than delayed.

// File: rtl/nlm_pkg.sv
package nlm_pkg;

  localparam int TENTHS_MAX = 10;

  typedef enum logic [1:0] {
    CS_OFF = 2'd0,
    CS_BYP = 2'd1,
    CS_POS = 2'd2,
    CS_NEG = 2'd3
  } cell_state_e;

  // bit0 left-high, bit1 left-low, bit2 right-high, bit3 right-low
  function automatic logic [3:0] leg_drive(cell_state_e s);
    logic [3:0] d;
    case (s)
      CS_POS:  d = 4'b1001;
      CS_NEG:  d = 4'b0110;
      CS_BYP:  d = 4'b0101;
      default: d = 4'b0000;
    endcase
    return d;
  endfunction

  // smallest fraction count f with 10*f >= tenths * 2^frac_w
  function automatic int thr_point(int tenths, int frac_w);
    return ((tenths << frac_w) + 9) / 10;
  endfunction

endpackage

// File: rtl/nlm_thr_reg.sv
module nlm_thr_reg #(
  parameter int FRAC_W  = 10,
  parameter int THR_RST = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              smp_en,
  input  logic              thr_wr,
  input  logic [3:0]        thr_val,
  output logic [3:0]        thr_q,
  output logic [FRAC_W:0]   thr_fix
);
  import nlm_pkg::*;

  logic       load_ok;
  logic [3:0] thr_sat;

  assign load_ok = thr_wr & ~smp_en;
  assign thr_sat = (thr_val > 4'(TENTHS_MAX)) ? 4'(TENTHS_MAX) : thr_val;

  always_ff @(posedge clk) begin
    if (!rst_n)       thr_q <= 4'(THR_RST);
    else if (load_ok) thr_q <= thr_sat;
  end

  assign thr_fix = (FRAC_W+1)'(thr_point(int'(thr_q), FRAC_W));

endmodule

// File: rtl/nlm_quant.sv
module nlm_quant #(
  parameter int NCELL  = 5,
  parameter int REF_W  = 16,
  parameter int FRAC_W = 10,
  parameter int IDX_W  = 4
) (
  input  logic signed [REF_W-1:0] ref_in,
  input  logic [FRAC_W:0]         thr_fix,
  output logic signed [IDX_W-1:0] lvl,
  output logic                    step_up,
  output logic                    clamp_hit
);
  localparam int IP_W = REF_W - FRAC_W;
  localparam int SW   = IP_W + 1;
  localparam logic [SW-1:0] NC_S = SW'(NCELL);

  logic              neg;
  logic [REF_W-1:0]  mag;
  logic [IP_W-1:0]   ipart;
  logic [FRAC_W-1:0] frac;
  logic [SW-1:0]     sum;
  logic [SW-1:0]     sum_c;
  logic [IDX_W-1:0]  idx_u;

  assign neg   = ref_in[REF_W-1];
  assign mag   = neg ? (~ref_in + 1'b1) : ref_in;
  assign ipart = mag[REF_W-1:FRAC_W];
  assign frac  = mag[FRAC_W-1:0];

  assign step_up   = (frac != '0) && ({1'b0, frac} >= thr_fix);
  assign sum       = {1'b0, ipart} + SW'(step_up);
  assign clamp_hit = sum > NC_S;
  assign sum_c     = clamp_hit ? NC_S : sum;
  assign idx_u     = IDX_W'(sum_c);
  assign lvl       = neg ? (~idx_u + 1'b1) : idx_u;

endmodule

// File: rtl/nlm_cell_drv.sv
module nlm_cell_drv #(
  parameter int CELL_IX = 0,
  parameter int IDX_W   = 4
) (
  input  logic signed [IDX_W-1:0] lvl,
  output logic [3:0]              legs
);
  import nlm_pkg::*;

  localparam logic signed [IDX_W-1:0] K = IDX_W'(CELL_IX);

  cell_state_e st;

  always_comb begin
    if (lvl > K)       st = CS_POS;
    else if (lvl < -K) st = CS_NEG;
    else               st = CS_BYP;
  end

  assign legs = leg_drive(st);

endmodule

// File: rtl/stair_nlm.sv
module stair_nlm #(
  parameter int NCELL   = 5,
  parameter int REF_W   = 16,
  parameter int FRAC_W  = 10,
  parameter int THR_RST = 5,
  localparam int IDX_W  = $clog2(NCELL + 1) + 1,
  localparam int G_W    = 4 * NCELL
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    smp_en,
  input  logic signed [REF_W-1:0] ref_in,
  input  logic                    thr_wr,
  input  logic [3:0]              thr_val,
  output logic signed [IDX_W-1:0] lvl_idx,
  output logic [G_W-1:0]          gate
);

  logic [3:0]              thr_q;
  logic [FRAC_W:0]         thr_fix;
  logic signed [IDX_W-1:0] lvl_nx;
  logic                    step_up;
  logic                    clamp_hit;
  logic [G_W-1:0]          gate_nx;

  nlm_thr_reg #(.FRAC_W(FRAC_W), .THR_RST(THR_RST)) u_thr (
    .clk(clk), .rst_n(rst_n), .smp_en(smp_en), .thr_wr(thr_wr),
    .thr_val(thr_val), .thr_q(thr_q), .thr_fix(thr_fix)
  );

  nlm_quant #(.NCELL(NCELL), .REF_W(REF_W), .FRAC_W(FRAC_W), .IDX_W(IDX_W)) u_quant (
    .ref_in(ref_in), .thr_fix(thr_fix), .lvl(lvl_nx),
    .step_up(step_up), .clamp_hit(clamp_hit)
  );

  for (genvar k = 0; k < NCELL; k++) begin : g_cell
    nlm_cell_drv #(.CELL_IX(k), .IDX_W(IDX_W)) u_drv (
      .lvl(lvl_nx), .legs(gate_nx[4*k +: 4])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lvl_idx <= '0;
      gate    <= '0;
    end else if (smp_en) begin
      lvl_idx <= lvl_nx;
      gate    <= gate_nx;
    end
  end

endmodule

// File: rtl/nlm_chk.sv
module nlm_chk #(
  parameter int NCELL = 5,
  parameter int IDX_W = 4
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    smp_en,
  input logic                    ref_msb,
  input logic [3:0]              thr_q,
  input logic                    step_up,
  input logic                    clamp_hit,
  input logic signed [IDX_W-1:0] lvl_idx,
  input logic [4*NCELL-1:0]      gate
);
  localparam logic signed [IDX_W-1:0] NP = IDX_W'(NCELL);
  localparam logic signed [IDX_W-1:0] NN = -NP;

  logic clash;
  always_comb begin
    clash = 1'b0;
    for (int k = 0; k < NCELL; k++)
      clash = clash | (gate[4*k] & gate[4*k+1]) | (gate[4*k+2] & gate[4*k+3]);
  end

  // R5
  lvl_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lvl_idx <= NP) && (lvl_idx >= NN));

  // R5
  clamp_pos_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_en && clamp_hit && !ref_msb) |=> (lvl_idx == NP));

  // R5
  clamp_neg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_en && clamp_hit && ref_msb) |=> (lvl_idx == NN));

  // R10
  leg_excl_chk: assert property (@(posedge clk) disable iff (!rst_n) !clash);

  // R6
  thr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    smp_en |=> $stable(thr_q));

  // R4
  thr_max_chk: assert property (@(posedge clk) disable iff (!rst_n) thr_q <= 4'd10);

  // R4
  trunc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (thr_q == 4'd10) |-> !step_up);

  // R7
  hold_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !smp_en |=> ($stable(lvl_idx) && $stable(gate)));

  // R8
  cell0_pos_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lvl_idx > 0) |-> (gate[3:0] == 4'b1001));

endmodule

bind stair_nlm nlm_chk #(.NCELL(NCELL), .IDX_W(IDX_W)) u_nlm_chk (
  .clk(clk), .rst_n(rst_n), .smp_en(smp_en), .ref_msb(ref_in[REF_W-1]),
  .thr_q(thr_q), .step_up(step_up), .clamp_hit(clamp_hit),
  .lvl_idx(lvl_idx), .gate(gate)
);

// File: tb/test_stair_nlm.sv
module test_stair_nlm;
  localparam int NCELL  = 5;
  localparam int REF_W  = 16;
  localparam int FRAC_W = 10;
  localparam int IDX_W  = $clog2(NCELL + 1) + 1;
  localparam int LVL    = 1 << FRAC_W;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic smp_en = 1'b0;
  logic signed [REF_W-1:0] ref_in = '0;
  logic thr_wr = 1'b0;
  logic [3:0] thr_val = '0;
  logic signed [IDX_W-1:0] lvl_idx;
  logic [4*NCELL-1:0] gate;

  int ntest = 0;
  int nfail = 0;
  int thr_m = 5;
  bit done = 1'b0;

  always #5 clk = ~clk;

  stair_nlm #(.NCELL(NCELL), .REF_W(REF_W), .FRAC_W(FRAC_W)) i_stair_nlm (
    .clk(clk), .rst_n(rst_n), .smp_en(smp_en), .ref_in(ref_in),
    .thr_wr(thr_wr), .thr_val(thr_val), .lvl_idx(lvl_idx), .gate(gate)
  );

  function automatic int exp_lvl(int r, int t);
    int m, ip, fr, q;
    m  = (r < 0) ? -r : r;
    ip = m / LVL;
    fr = m - ip * LVL;
    q  = ip + (((fr > 0) && (fr * 10 >= t * LVL)) ? 1 : 0);
    if (q > NCELL) q = NCELL;
    return (r < 0) ? -q : q;
  endfunction

  function automatic logic [4*NCELL-1:0] exp_gate(int q);
    logic [4*NCELL-1:0] g;
    for (int k = 0; k < NCELL; k++) begin
      if (k < q)       g[4*k +: 4] = 4'b1001;
      else if (k < -q) g[4*k +: 4] = 4'b0110;
      else             g[4*k +: 4] = 4'b0101;
    end
    return g;
  endfunction

  task automatic chk(string tag, int act, int exp);
    ntest++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic chk_out(string tag, int q);
    chk({tag, " level"}, int'(lvl_idx), q);
    ntest++;
    if (gate !== exp_gate(q)) begin
      nfail++;
      $display("FAIL R8 %s gate actual=%h expected=%h", tag, gate, exp_gate(q));
    end
  endtask

  task automatic sample(int r, string tag);
    @(negedge clk);
    smp_en = 1'b1;
    ref_in = REF_W'(r);
    @(negedge clk);
    smp_en = 1'b0;
    chk_out(tag, exp_lvl(r, thr_m));
  endtask

  task automatic set_thr(int v);
    @(negedge clk);
    thr_wr  = 1'b1;
    thr_val = 4'(v);
    @(negedge clk);
    thr_wr  = 1'b0;
    thr_m   = (v > 10) ? 10 : v;
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", ntest, nfail);
      $finish;
    end
  endtask

  initial begin
    #1_900_000;
    ntest++;
    nfail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    void'($urandom(32'd7321));
    repeat (3) @(negedge clk);
    chk("R9 reset level", int'(lvl_idx), 0);
    chk("R9 reset gate", int'(gate), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R9 after release gate", int'(gate), 0);

    // R2 default threshold 5
    sample(511, "R2 below half");
    sample(512, "R2 at half");
    sample(LVL + 511, "R2 one plus below half");
    // R3 symmetry
    sample(-512, "R3 neg at half");
    sample(-511, "R3 neg below half");
    sample(-(2 * LVL + 700), "R3 neg two plus");
    // R1 exact levels
    sample(3 * LVL, "R1 exact three");
    sample(0, "R1 zero");
    // R4 thresholds
    set_thr(4);
    sample(LVL + 409, "R4 t4 just below");
    sample(LVL + 410, "R4 t4 at point");
    sample(-(LVL + 410), "R3 R4 t4 negative");
    set_thr(0);
    sample(LVL + 1, "R4 t0 ceiling");
    sample(LVL, "R4 t0 exact");
    set_thr(10);
    sample(2 * LVL - 1, "R4 t10 floor");
    set_thr(0);
    set_thr(13);
    sample(2 * LVL - 1, "R4 saturate write");
    // R5 clamp
    sample(32767, "R5 clamp pos");
    sample(-32768, "R5 clamp neg");
    set_thr(5);
    sample(5 * LVL + 600, "R5 past top");
    sample(4 * LVL + 600, "R5 reach top");

    // R6 write colliding with sample is dropped
    @(negedge clk);
    thr_wr = 1'b1; thr_val = 4'd0; smp_en = 1'b1; ref_in = REF_W'(LVL + 76);
    @(negedge clk);
    thr_wr = 1'b0; smp_en = 1'b0;
    chk_out("R6 collide sample", exp_lvl(LVL + 76, 5));
    sample(LVL + 76, "R6 write dropped");

    // R7 hold without sample
    sample(3 * LVL + 900, "R7 setup");
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      ref_in = REF_W'(-(i + 1) * 900);
      chk_out("R7 hold", exp_lvl(3 * LVL + 900, 5));
    end

    // random mix
    for (int n = 0; n < 400; n++) begin
      int r;
      if ($urandom_range(0, 9) == 0) set_thr(int'($urandom_range(0, 15)));
      if ($urandom_range(0, 3) == 0) begin
        r = int'($urandom_range(0, 6)) * LVL + (thr_m * LVL + 9) / 10
            - int'($urandom_range(0, 1));
        if ($urandom_range(0, 1) == 1) r = -r;
      end else begin
        r = int'($urandom_range(0, 13000)) - 6500;
      end
      sample(r, "R1 R8 random");
    end

    finish_run();
  end

endmodule